// File: doc/BRIEF.md
# Cache Tag Store with Equality Compare

This block keeps one small tag per cache line and answers a single question every clock: does the tag presented on the data input equal the tag held at the presented address? It is a 4096-word by 4-bit store with an equality comparator on its data port. It also has a one-command clear that empties the whole store in one clock. Wider tags are built by giving several instances the same address and controls, each with a slice of the tag, and ANDing their `match` outputs.

Three active-low controls select the operation in each cycle. Clear wins over everything. Write comes next. With write inactive, a low output enable gives a read, and all three high gives a compare. All results are registered: the address, data and controls sampled at one rising edge show up on the outputs just after that edge. The input synchronous reset empties the store and zeroes the outputs, just as a clear does.

Top module: `tag_match_ram`

## Requirements
- R1: In a compare cycle (`we_n`, `oe_n`, `clr_n` all 1), `match` becomes 1 after the edge if all four bits of `din` equal the stored word at `addr`, and 0 if any single bit differs.
- R2: In a write cycle (`we_n`=0, `clr_n`=1), `din` is stored at `addr` whatever the value of `oe_n`, and later reads and compares of that address see it.
- R3: In a read cycle (`we_n`=1, `clr_n`=1, `oe_n`=0), `rdata` carries the stored word and `rdata_en` is 1 after the edge. After any other non-clear cycle, `rdata_en` is 0 and `rdata` is 0.
- R4: After a read or a write cycle, `match` is 1, even when `din` differs from the stored word during the read.
- R5: A clear cycle (`clr_n`=0) makes every entry read and compare as 4'b0000 from the next cycle on. It overrides a write that is requested in the same cycle.
- R6: While `rst` is 1, `match`, `rdata_en` and `rdata` are 0 after each edge, and the store is emptied, so every entry compares equal to 4'b0000.
- R7: Outputs are registered. They change only at the rising edge that samples the inputs, so new inputs do not affect the outputs before that edge.
- R8: Two instances that share address and controls and hold the two nibbles of an 8-bit tag give an ANDed `match` that is 1 exactly when the whole byte is equal.
- R9: A write changes only the addressed entry. Other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Entry address |
| din | input | 4 | Tag to store or to compare |
| we_n | input | 1 | Write request, active low |
| oe_n | input | 1 | Read request, active low |
| clr_n | input | 1 | Whole-store clear, active low, highest priority |
| rdata | output | 4 | Registered read word, 0 when not reading |
| rdata_en | output | 1 | Registered: previous cycle was a read |
| match | output | 1 | Registered equality result |

## Verification
The comparator is tried first with exact-equality tags. It is then tried with tags that flip one bit at a time in each nibble, which shows that every bit position takes part in the compare and that either instance alone can pull the combined 8-bit result low. Reads made with an unrelated `din` show that the read path forces `match` high instead of comparing against the input. Compares against zero are made on a never-written entry, after reset, and after a clear that coincides with a write. These tell the valid-bit emptying apart from the data array and show that clear takes priority.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

    typedef enum logic [1:0] {
        MODE_CMP   = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_CLEAR = 2'd3
    } tag_mode_e;

    // Priority: clear, then write, then read, else compare
    function automatic tag_mode_e mode_of(input logic we_n, input logic oe_n,
                                          input logic clr_n);
        if (!clr_n)     return MODE_CLEAR;
        else if (!we_n) return MODE_WRITE;
        else if (!oe_n) return MODE_READ;
        else            return MODE_CMP;
    endfunction

endpackage

// File: rtl/tagram_decode.sv
module tagram_decode
    import tagram_pkg::*;
(
    input  logic      we_n,
    input  logic      oe_n,
    input  logic      clr_n,
    output tag_mode_e mode
);
    always_comb mode = mode_of(we_n, oe_n, clr_n);
endmodule

// File: rtl/tagram_store.sv
module tagram_store #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  live;

    // Valid bits empty the store in one clock
    always_ff @(posedge clk) begin
        if (rst || wipe)
            live <= '0;
        else if (wr)
            live[addr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr && !wipe && !rst)
            cells[addr] <= wdata;
    end

    always_comb word = live[addr] ? cells[addr] : '0;
endmodule

// File: rtl/tagram_result.sv
module tagram_result
    import tagram_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  tag_mode_e         mode,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en,
    output logic              match
);
    logic [DATA_W-1:0] lhs, rhs, bit_eq;
    logic              all_eq;

    // Read compares the word with itself, write compares input with itself
    always_comb begin
        lhs = (mode == MODE_WRITE) ? din : word;
        rhs = (mode == MODE_READ)  ? word : din;
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign bit_eq[b] = ~(lhs[b] ^ rhs[b]);
    end

    always_comb all_eq = &bit_eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            match    <= 1'b0;
            rdata    <= '0;
            rdata_en <= 1'b0;
        end else begin
            match    <= (mode == MODE_CLEAR) ? 1'b0 : all_eq;
            rdata_en <= (mode == MODE_READ);
            rdata    <= (mode == MODE_READ) ? word : '0;
        end
    end
endmodule

// File: rtl/tag_match_ram.sv
module tag_match_ram
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              clr_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en,
    output logic              match
);
    tag_mode_e         mode;
    logic [DATA_W-1:0] word;

    tagram_decode u_dec (
        .we_n  (we_n),
        .oe_n  (oe_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    tagram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wipe  (mode == MODE_CLEAR),
        .wr    (mode == MODE_WRITE),
        .addr  (addr),
        .wdata (din),
        .word  (word)
    );

    tagram_result #(.DATA_W(DATA_W)) u_res (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .word     (word),
        .din      (din),
        .rdata    (rdata),
        .rdata_en (rdata_en),
        .match    (match)
    );
endmodule

// File: rtl/tagram_chk.sv
module tagram_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic              we_n,
    input logic              oe_n,
    input logic              clr_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_en,
    input logic              match
);
    logic is_wr, is_rd, is_clr;
    always_comb begin
        is_clr = !clr_n;
        is_wr  = clr_n && !we_n;
        is_rd  = clr_n && we_n && !oe_n;
    end

    AST_WRITE_MATCHES: assert property (@(posedge clk) disable iff (rst)
        is_wr |=> match); // R4
    AST_READ_MATCHES: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> (match && rdata_en)); // R4
    AST_NO_RDATA_OUTSIDE_READ: assert property (@(posedge clk) disable iff (rst)
        (!is_rd && !is_clr) |=> (!rdata_en && rdata == '0)); // R3
    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        is_wr ##1 (is_rd && addr == $past(addr)) |=> (rdata == $past(din, 2))); // R2
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        is_clr ##1 is_rd |=> (rdata == '0)); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!match && !rdata_en && rdata == '0)); // R6
endmodule

bind tag_match_ram tagram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .din      (din),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .clr_n    (clr_n),
    .rdata    (rdata),
    .rdata_en (rdata_en),
    .match    (match)
);

// File: tb/tb_tag_match_ram.sv
module tb_tag_match_ram;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] addr;
    logic [7:0]  tag;
    logic        we_n, oe_n, clr_n;
    logic [3:0]  rd_lo, rd_hi;
    logic        en_lo, en_hi, m_lo, m_hi;
    logic        m_all;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tag_match_ram dut (
        .clk(clk), .rst(rst), .addr(addr), .din(tag[3:0]),
        .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n),
        .rdata(rd_lo), .rdata_en(en_lo), .match(m_lo)
    );

    tag_match_ram dut_hi (
        .clk(clk), .rst(rst), .addr(addr), .din(tag[7:4]),
        .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n),
        .rdata(rd_hi), .rdata_en(en_hi), .match(m_hi)
    );

    assign m_all = m_lo & m_hi; // R8 cascade

    typedef struct packed {
        logic [1:0]  op;     // 0 compare, 1 read, 2 write, 3 clear
        logic [11:0] a;
        logic [7:0]  d;
        logic        exp_m;
        logic [7:0]  exp_r;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 12'h005, 8'hA5, 1'b1, 8'h00},
        '{2'd0, 12'h005, 8'hA5, 1'b1, 8'h00},
        '{2'd0, 12'h005, 8'hA4, 1'b0, 8'h00},
        '{2'd0, 12'h005, 8'hA7, 1'b0, 8'h00},
        '{2'd0, 12'h005, 8'hA1, 1'b0, 8'h00},
        '{2'd0, 12'h005, 8'hAD, 1'b0, 8'h00},
        '{2'd0, 12'h005, 8'hB5, 1'b0, 8'h00},
        '{2'd1, 12'h005, 8'h00, 1'b1, 8'hA5},
        '{2'd2, 12'hFFF, 8'h3C, 1'b1, 8'h00},
        '{2'd0, 12'hFFF, 8'h3C, 1'b1, 8'h00},
        '{2'd0, 12'h000, 8'h00, 1'b1, 8'h00},
        '{2'd1, 12'hFFF, 8'h5A, 1'b1, 8'h3C},
        '{2'd0, 12'h005, 8'hA5, 1'b1, 8'h00},
        '{2'd3, 12'h000, 8'h00, 1'b0, 8'h00},
        '{2'd0, 12'h005, 8'h00, 1'b1, 8'h00},
        '{2'd0, 12'hFFF, 8'h3C, 1'b0, 8'h00},
        '{2'd1, 12'hFFF, 8'h00, 1'b1, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [11:0] a, input logic [7:0] d);
        addr  = a;
        tag   = d;
        clr_n = (op != 2'd3);
        we_n  = (op != 2'd2);
        oe_n  = (op != 2'd1);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        drive(2'd0, 12'h000, 8'h00);
        @(negedge clk);
        step();
        // R6: outputs quiet under reset
        check("R6 match", {31'd0, m_all}, 32'd0);
        check("R6 rdata_en", {30'd0, en_hi, en_lo}, 32'd0);
        check("R6 rdata", {24'd0, rd_hi, rd_lo}, 32'd0);
        rst = 1'b0;
        drive(2'd0, 12'h123, 8'h00);
        step();
        check("R6 store empty after reset", {31'd0, m_all}, 32'd1);

        // vector table: R1 R3 R4 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].a, VECS[i].d);
            step();
            if (VECS[i].op != 2'd3) begin
                check("R1/R4/R8 match", {31'd0, m_all}, {31'd0, VECS[i].exp_m});
                check("R3 rdata", {24'd0, rd_hi, rd_lo}, {24'd0, VECS[i].exp_r});
                check("R3 rdata_en", {31'd0, en_lo & en_hi},
                      {31'd0, VECS[i].op == 2'd1});
            end
        end

        // R5: clear overrides a write in the same cycle
        drive(2'd3, 12'h010, 8'hFF);
        we_n = 1'b0;
        step();
        drive(2'd0, 12'h010, 8'hFF);
        step();
        check("R5 dropped write compare", {31'd0, m_all}, 32'd0);
        drive(2'd1, 12'h010, 8'h00);
        step();
        check("R5 dropped write read", {24'd0, rd_hi, rd_lo}, 32'd0);

        // R2: write with read request also active still writes
        drive(2'd2, 12'h020, 8'h5A);
        oe_n = 1'b0;
        step();
        check("R2 write with oe_n low match", {31'd0, m_all}, 32'd1);
        check("R2 write with oe_n low no rdata", {31'd0, en_lo}, 32'd0);
        drive(2'd1, 12'h020, 8'h00);
        step();
        check("R2 readback", {24'd0, rd_hi, rd_lo}, 32'h5A);

        // R7: outputs only change at the edge
        drive(2'd0, 12'h020, 8'h5A);
        step();
        check("R7 equal compare", {31'd0, m_all}, 32'd1);
        drive(2'd0, 12'h020, 8'h5B);
        #1;
        check("R7 held before edge", {31'd0, m_all}, 32'd1);
        step();
        check("R7 updated after edge", {31'd0, m_all}, 32'd0);
        check("R1 low instance alone", {31'd0, m_lo}, 32'd0);
        check("R8 high nibble still equal", {31'd0, m_hi}, 32'd1);

        finish_run();
    end
endmodule